// File: doc/BRIEF.md
# Two-Pipe Layer Compositor

This block merges up to four rectangular layers into a single RGB stream, one result per scan position. Every layer carries an enable, a signed on-screen origin, a width and height, a pipe select, a priority level and an optional global alpha. Upstream fetch logic supplies one ARGB pixel per layer for the current position together with the x/y coordinate. The block does not fetch memory and does not scale.

Composition takes two steps. Within each of the two pipes, the covering layer with the highest priority supplies the colour. The pipe 1 result is then alpha-blended over the pipe 0 result, and the pipe 0 result sits over a fixed background colour. A build-time option reproduces a known silicon behaviour. When it is set, the bottom layer of pipe 0 shows the background instead of its pixels wherever those pixels carry alpha.

Top module: `pipe_comp_top`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `outValid` is low.
- R2: Each cycle in which `pixValid` is high produces exactly one result. `outValid` goes high exactly two clock edges later, and results leave in input order.
- R3: A layer covers position (x, y) when it is enabled, X <= x < X+W and Y <= y < Y+H. The origin (X, Y) is a signed two's-complement value, so a negative origin clips the layer at the left or top edge.
- R4: Within one pipe, the covering layer with the larger priority value wins. When two covering layers have equal priority, the one with the lower layer index wins.
- R5: A pipe with no covering layer is empty. If both pipes are empty, the output is the background colour `BG_COLOR`, which defaults to 24'h000000. A disabled layer never contributes.
- R6: If pipe 1 is empty, the pipe 0 winner's RGB passes through unchanged and its alpha is ignored, unless R10 applies.
- R7: Pixels are packed as A[31:24], R[23:16], G[15:8], B[7:0]. If pipe 1 is non-empty, each output channel equals (a*c1 + (255-a)*c0 + 127)/255 with integer division. Here a is the effective alpha of the pipe 1 winner, c1 is its channel, and c0 is the pipe 0 result (or the background if pipe 0 is empty).
- R8: A layer's effective alpha is its pixel alpha when its global-alpha enable is low. When the enable is high, it is (pixel_alpha*global_alpha + 127)/255.
- R9: A position with x >= `dispW` or y >= `dispH` outputs the background colour, whatever the layers hold.
- R10: With `LOW_ALPHA_BLANK`=1, find the lowest-priority enabled pipe 0 layer. If several share that priority, take the highest index among them. If this layer wins pipe 0 at a position and its effective alpha there is below 255, the pipe 0 result becomes the background colour. With `LOW_ALPHA_BLANK`=0 this never happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixValid | input | 1 | Position and layer pixels are valid this cycle |
| posX | input | COORD_W | Current column |
| posY | input | COORD_W | Current row |
| dispW | input | COORD_W | Display width |
| dispH | input | COORD_W | Display height |
| layerEn | input | NUM_LAYERS | Per-layer enable |
| layerX | input | NUM_LAYERS*COORD_W | Signed origin x, layer i at [i*COORD_W +: COORD_W] |
| layerY | input | NUM_LAYERS*COORD_W | Signed origin y |
| layerW | input | NUM_LAYERS*COORD_W | Layer width |
| layerH | input | NUM_LAYERS*COORD_W | Layer height |
| layerPipe | input | NUM_LAYERS | Pipe select, 0 or 1 |
| layerPrio | input | NUM_LAYERS*PRIO_W | Priority, larger is higher |
| glbAlphaEn | input | NUM_LAYERS | Global alpha enable |
| glbAlpha | input | NUM_LAYERS*8 | Global alpha value |
| layerPix | input | NUM_LAYERS*32 | ARGB pixel of each layer at this position |
| outValid | output | 1 | Result valid |
| outRgb | output | 24 | Composited RGB pixel |

## Verification
The assertions assume that `pixValid` is low during reset. They also assume that `posX`, `posY`, `dispW`, `dispH` and `layerEn` are stable around the sampling edge of a valid cycle. Background-only properties depend on that: a position outside the display, or a cycle with no layer enabled, must show up as `BG_COLOR` two edges later. The stimulus changes inputs only on falling edges and holds `pixValid` low throughout reset. It keeps every layer rectangle and coordinate inside the signed 12-bit range, so the bench's integer geometry model matches the hardware exactly.

// File: rtl/pipe_comp_pkg.sv
package pipe_comp_pkg;

  typedef logic [31:0] argb_t;

  // strobes from the selection stage to the blend stage
  typedef struct packed {
    logic valid;
    logic inDisp;
    logic p0Hit;
    logic p1Hit;
    logic p0IsBottom;
  } ctlStrobes_t;

  typedef struct packed {
    argb_t      p0Pix;
    logic       p0GEn;
    logic [7:0] p0GA;
    argb_t      p1Pix;
    logic       p1GEn;
    logic [7:0] p1GA;
  } pipeData_t;

  function automatic logic [7:0] effAlpha(logic [7:0] pa, logic en, logic [7:0] ga);
    logic [15:0] prod;
    prod = {8'd0, pa} * {8'd0, ga} + 16'd127;
    return en ? 8'(prod / 16'd255) : pa;
  endfunction

  function automatic logic [7:0] mixChan(logic [7:0] a, logic [7:0] c1, logic [7:0] c0);
    logic [16:0] s;
    s = {9'd0, a} * {9'd0, c1} + {9'd0, 8'hFF - a} * {9'd0, c0} + 17'd127;
    return 8'(s / 17'd255);
  endfunction

endpackage

// File: rtl/pipe_comp_ctrl.sv
module pipe_comp_ctrl
  import pipe_comp_pkg::*;
#(
  parameter int NL = 4,
  parameter int CW = 12,
  parameter int PW = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic [CW-1:0]    posX,
  input  logic [CW-1:0]    posY,
  input  logic [CW-1:0]    dispW,
  input  logic [CW-1:0]    dispH,
  input  logic [NL-1:0]    layerEn,
  input  logic [NL*CW-1:0] layerX,
  input  logic [NL*CW-1:0] layerY,
  input  logic [NL*CW-1:0] layerW,
  input  logic [NL*CW-1:0] layerH,
  input  logic [NL-1:0]    layerPipe,
  input  logic [NL*PW-1:0] layerPrio,
  input  logic [NL-1:0]    glbAlphaEn,
  input  logic [NL*8-1:0]  glbAlpha,
  input  logic [NL*32-1:0] layerPix,
  output ctlStrobes_t      ctl,
  output pipeData_t        data
);
  localparam int SW = CW + 2;
  localparam int IW = (NL > 1) ? $clog2(NL) : 1;

  logic [NL-1:0] covered;

  for (genvar g = 0; g < NL; g++) begin : gCov
    logic signed [SW-1:0] ox, oy, ex, ey, px, py;
    assign ox = $signed({{2{layerX[g*CW+CW-1]}}, layerX[g*CW +: CW]});
    assign oy = $signed({{2{layerY[g*CW+CW-1]}}, layerY[g*CW +: CW]});
    assign ex = ox + $signed({2'b00, layerW[g*CW +: CW]});
    assign ey = oy + $signed({2'b00, layerH[g*CW +: CW]});
    assign px = $signed({2'b00, posX});
    assign py = $signed({2'b00, posY});
    assign covered[g] = layerEn[g] && (px >= ox) && (px < ex) && (py >= oy) && (py < ey);
  end

  logic          hit0, hit1, botFound;
  logic [IW-1:0] idx0, idx1, botIdx;
  logic [PW-1:0] pr0, pr1, botPr;

  always_comb begin
    hit0 = 1'b0; idx0 = '0; pr0 = '0;
    hit1 = 1'b0; idx1 = '0; pr1 = '0;
    botFound = 1'b0; botIdx = '0; botPr = '0;
    for (int i = 0; i < NL; i++) begin
      // strict compare keeps the lower index on a tie
      if (covered[i] && !layerPipe[i] && (!hit0 || layerPrio[i*PW +: PW] > pr0)) begin
        hit0 = 1'b1; idx0 = IW'(i); pr0 = layerPrio[i*PW +: PW];
      end
      if (covered[i] && layerPipe[i] && (!hit1 || layerPrio[i*PW +: PW] > pr1)) begin
        hit1 = 1'b1; idx1 = IW'(i); pr1 = layerPrio[i*PW +: PW];
      end
      // bottom of pipe 0: lowest priority, later index on a tie
      if (layerEn[i] && !layerPipe[i] && (!botFound || layerPrio[i*PW +: PW] <= botPr)) begin
        botFound = 1'b1; botIdx = IW'(i); botPr = layerPrio[i*PW +: PW];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl  <= '0;
      data <= '0;
    end else begin
      ctl.valid      <= pixValid;
      ctl.inDisp     <= (posX < dispW) && (posY < dispH);
      ctl.p0Hit      <= hit0;
      ctl.p1Hit      <= hit1;
      ctl.p0IsBottom <= hit0 && botFound && (idx0 == botIdx);
      data.p0Pix     <= layerPix[32*idx0 +: 32];
      data.p0GEn     <= glbAlphaEn[idx0];
      data.p0GA      <= glbAlpha[8*idx0 +: 8];
      data.p1Pix     <= layerPix[32*idx1 +: 32];
      data.p1GEn     <= glbAlphaEn[idx1];
      data.p1GA      <= glbAlpha[8*idx1 +: 8];
    end
  end

endmodule

// File: rtl/pipe_comp_dp.sv
module pipe_comp_dp
  import pipe_comp_pkg::*;
#(
  parameter bit          QUIRK = 1'b0,
  parameter logic [23:0] BG    = 24'h000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  pipeData_t   data,
  output logic        outValid,
  output logic [23:0] outRgb
);
  logic [7:0]  a0, a1;
  logic        blank;
  logic [23:0] base, mixed;

  always_comb begin
    a0    = effAlpha(data.p0Pix[31:24], data.p0GEn, data.p0GA);
    a1    = effAlpha(data.p1Pix[31:24], data.p1GEn, data.p1GA);
    blank = QUIRK && ctl.p0IsBottom && (a0 != 8'hFF);
    base  = (!ctl.p0Hit || blank) ? BG : data.p0Pix[23:0];
    mixed = base;
    if (ctl.p1Hit) begin
      for (int c = 0; c < 3; c++)
        mixed[c*8 +: 8] = mixChan(a1, data.p1Pix[c*8 +: 8], base[c*8 +: 8]);
    end
    if (!ctl.inDisp) mixed = BG;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRgb   <= BG;
    end else begin
      outValid <= ctl.valid;
      outRgb   <= mixed;
    end
  end

endmodule

// File: rtl/pipe_comp_top.sv
module pipe_comp_top
  import pipe_comp_pkg::*;
#(
  parameter int          NUM_LAYERS      = 4,
  parameter int          COORD_W         = 12,
  parameter int          PRIO_W          = 2,
  parameter bit          LOW_ALPHA_BLANK = 1'b0,
  parameter logic [23:0] BG_COLOR        = 24'h000000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          pixValid,
  input  logic [COORD_W-1:0]            posX,
  input  logic [COORD_W-1:0]            posY,
  input  logic [COORD_W-1:0]            dispW,
  input  logic [COORD_W-1:0]            dispH,
  input  logic [NUM_LAYERS-1:0]         layerEn,
  input  logic [NUM_LAYERS*COORD_W-1:0] layerX,
  input  logic [NUM_LAYERS*COORD_W-1:0] layerY,
  input  logic [NUM_LAYERS*COORD_W-1:0] layerW,
  input  logic [NUM_LAYERS*COORD_W-1:0] layerH,
  input  logic [NUM_LAYERS-1:0]         layerPipe,
  input  logic [NUM_LAYERS*PRIO_W-1:0]  layerPrio,
  input  logic [NUM_LAYERS-1:0]         glbAlphaEn,
  input  logic [NUM_LAYERS*8-1:0]       glbAlpha,
  input  logic [NUM_LAYERS*32-1:0]      layerPix,
  output logic                          outValid,
  output logic [23:0]                   outRgb
);
  ctlStrobes_t ctl;
  pipeData_t   data;

  pipe_comp_ctrl #(.NL(NUM_LAYERS), .CW(COORD_W), .PW(PRIO_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .posX(posX), .posY(posY),
    .dispW(dispW), .dispH(dispH), .layerEn(layerEn), .layerX(layerX),
    .layerY(layerY), .layerW(layerW), .layerH(layerH), .layerPipe(layerPipe),
    .layerPrio(layerPrio), .glbAlphaEn(glbAlphaEn), .glbAlpha(glbAlpha),
    .layerPix(layerPix), .ctl(ctl), .data(data)
  );

  pipe_comp_dp #(.QUIRK(LOW_ALPHA_BLANK), .BG(BG_COLOR)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .data(data),
    .outValid(outValid), .outRgb(outRgb)
  );

endmodule

// File: rtl/pipe_comp_chk.sv
module pipe_comp_chk #(
  parameter int          NL = 4,
  parameter int          CW = 12,
  parameter logic [23:0] BG = 24'h000000
) (
  input logic          clk,
  input logic          rstN,
  input logic          pixValid,
  input logic [CW-1:0] posX,
  input logic [CW-1:0] posY,
  input logic [CW-1:0] dispW,
  input logic [CW-1:0] dispH,
  input logic [NL-1:0] layerEn,
  input logic          outValid,
  input logic [23:0]   outRgb
);
  // R1
  always @(negedge clk) begin
    if (!rstN) rst_out_low_chk: assert (!outValid);
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> ##1 outValid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> ##1 !outValid);

  // R9
  outside_disp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && (posX >= dispW || posY >= dispH)) |=> ##1 (outRgb == BG));

  // R5
  all_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && layerEn == '0) |=> ##1 (outRgb == BG));

endmodule

bind pipe_comp_top pipe_comp_chk #(.NL(NUM_LAYERS), .CW(COORD_W), .BG(BG_COLOR)) i_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .posX(posX), .posY(posY),
  .dispW(dispW), .dispH(dispH), .layerEn(layerEn), .outValid(outValid), .outRgb(outRgb)
);

// File: tb/test_pipe_comp_top.sv
module test_pipe_comp_top;
  localparam int NL = 4;
  localparam int CW = 12;
  localparam int PW = 2;
  localparam logic [23:0] BGC = 24'h000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixValid = 1'b0;
  logic [CW-1:0] posX = '0, posY = '0, dispW = 12'd100, dispH = 12'd80;

  int lx[NL], ly[NL], lw[NL], lh[NL], lprio[NL], lga[NL];
  bit len[NL], lpipe[NL], lgen[NL];
  logic [31:0] lpix[NL];

  logic [NL-1:0] layerEn, layerPipe, glbAlphaEn;
  logic [NL*CW-1:0] layerX, layerY, layerW, layerH;
  logic [NL*PW-1:0] layerPrio;
  logic [NL*8-1:0] glbAlpha;
  logic [NL*32-1:0] layerPix;
  logic outValid, outValidQ;
  logic [23:0] outRgb, outRgbQ;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      layerEn[i]            = len[i];
      layerPipe[i]          = lpipe[i];
      glbAlphaEn[i]         = lgen[i];
      layerX[i*CW +: CW]    = lx[i][CW-1:0];
      layerY[i*CW +: CW]    = ly[i][CW-1:0];
      layerW[i*CW +: CW]    = lw[i][CW-1:0];
      layerH[i*CW +: CW]    = lh[i][CW-1:0];
      layerPrio[i*PW +: PW] = lprio[i][PW-1:0];
      glbAlpha[i*8 +: 8]    = lga[i][7:0];
      layerPix[i*32 +: 32]  = lpix[i];
    end
  end

  pipe_comp_top #(.LOW_ALPHA_BLANK(1'b0)) i_pipe_comp_top (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .posX(posX), .posY(posY),
    .dispW(dispW), .dispH(dispH), .layerEn(layerEn), .layerX(layerX), .layerY(layerY),
    .layerW(layerW), .layerH(layerH), .layerPipe(layerPipe), .layerPrio(layerPrio),
    .glbAlphaEn(glbAlphaEn), .glbAlpha(glbAlpha), .layerPix(layerPix),
    .outValid(outValid), .outRgb(outRgb));

  pipe_comp_top #(.LOW_ALPHA_BLANK(1'b1)) i_pipe_comp_top_quirk (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .posX(posX), .posY(posY),
    .dispW(dispW), .dispH(dispH), .layerEn(layerEn), .layerX(layerX), .layerY(layerY),
    .layerW(layerW), .layerH(layerH), .layerPipe(layerPipe), .layerPrio(layerPrio),
    .glbAlphaEn(glbAlphaEn), .glbAlpha(glbAlpha), .layerPix(layerPix),
    .outValid(outValidQ), .outRgb(outRgbQ));

  typedef struct {
    logic [23:0] e0;
    logic [23:0] e1;
    string       req;
  } exp_t;
  exp_t sb[$];

  function automatic int effA(int i);
    int pa = int'(lpix[i][31:24]);
    return lgen[i] ? (pa * lga[i] + 127) / 255 : pa;
  endfunction

  function automatic logic [23:0] model(int x, int y, bit q);
    int w0 = -1, w1 = -1, b = -1, a;
    logic [23:0] base, r;
    bit cov;
    if (x >= int'(dispW) || y >= int'(dispH)) return BGC;
    for (int i = 0; i < NL; i++) begin
      cov = len[i] && x >= lx[i] && x < lx[i] + lw[i] && y >= ly[i] && y < ly[i] + lh[i];
      if (cov && !lpipe[i] && (w0 < 0 || lprio[i] > lprio[w0])) w0 = i;
      if (cov && lpipe[i] && (w1 < 0 || lprio[i] > lprio[w1])) w1 = i;
      if (len[i] && !lpipe[i] && (b < 0 || lprio[i] <= lprio[b])) b = i;
    end
    if (w0 < 0) base = BGC;
    else if (q && w0 == b && effA(w0) != 255) base = BGC;
    else base = lpix[w0][23:0];
    if (w1 < 0) return base;
    a = effA(w1);
    for (int c = 0; c < 3; c++)
      r[c*8 +: 8] = 8'((a * int'(lpix[w1][c*8 +: 8]) + (255 - a) * int'(base[c*8 +: 8]) + 127) / 255);
    return r;
  endfunction

  task automatic setLayer(int i, bit en, int x, int y, int w, int h, bit p, int pr,
                          bit ge, int ga, logic [31:0] px);
    len[i] = en; lx[i] = x; ly[i] = y; lw[i] = w; lh[i] = h;
    lpipe[i] = p; lprio[i] = pr; lgen[i] = ge; lga[i] = ga; lpix[i] = px;
  endtask

  task automatic sendPix(int x, int y, string req);
    exp_t e;
    @(negedge clk);
    posX = x[CW-1:0];
    posY = y[CW-1:0];
    pixValid = 1'b1;
    e.e0 = model(x, y, 1'b0);
    e.e1 = model(x, y, 1'b1);
    e.req = req;
    sb.push_back(e);
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 result with no pending item: actual %h expected none", outRgb);
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks += 2;
        if (outRgb !== e.e0) begin
          failures++;
          $display("FAIL %s base: actual %h expected %h", e.req, outRgb, e.e0);
        end
        if (outRgbQ !== e.e1) begin
          failures++;
          $display("FAIL %s quirk: actual %h expected %h", e.req, outRgbQ, e.e1);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) setLayer(i, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: actual %b expected 0", outValid);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      failures++;
      $display("FAIL R1 after reset: actual %b expected 0", outValid);
    end

    sendPix(5, 5, "R5 all off");

    setLayer(0, 1, 10, 10, 20, 20, 0, 1, 0, 0, 32'hFF112233);
    sendPix(15, 15, "R6 single opaque");
    sendPix(30, 15, "R3 right edge excluded");
    sendPix(29, 29, "R3 last inside");
    sendPix(15, 30, "R3 bottom edge excluded");

    lpix[0] = 32'h40112233;
    sendPix(15, 15, "R10 bottom with alpha");

    setLayer(1, 1, -5, -5, 20, 20, 0, 2, 0, 0, 32'h80445566);
    sendPix(0, 0, "R3 negative origin");
    sendPix(14, 14, "R4 higher priority wins");
    sendPix(15, 15, "R10 bottom only");

    lprio[1] = 1;
    sendPix(14, 14, "R4 tie lower index");

    setLayer(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
    lpix[0] = 32'hFF0000FF;
    setLayer(2, 1, 0, 0, 50, 50, 1, 0, 0, 0, 32'h80FF0000);
    sendPix(15, 15, "R7 half blend");
    repeat (2) @(negedge clk);
    checks++;
    if (outRgb !== 24'h80007F) begin
      failures++;
      $display("FAIL R7 fixed value: actual %h expected 80007f", outRgb);
    end
    lpix[2] = 32'h00FF0000;
    sendPix(15, 15, "R7 alpha zero");
    lpix[2] = 32'hFFFF0000;
    sendPix(15, 15, "R7 alpha full");
    sendPix(40, 40, "R5 pipe1 over background");

    lpix[2] = 32'hFF336699; lgen[2] = 1; lga[2] = 8'h80;
    sendPix(15, 15, "R8 global alpha");
    lpix[2] = 32'h80336699; lga[2] = 8'h40;
    sendPix(15, 15, "R8 global times pixel");

    setLayer(3, 1, 12, 12, 5, 5, 1, 3, 0, 0, 32'hC0ABCDEF);
    sendPix(13, 13, "R4 pipe1 priority");

    sendPix(120, 10, "R9 beyond width");
    sendPix(10, 90, "R9 beyond height");

    // latency check R2
    @(negedge clk);
    posX = 13; posY = 13; pixValid = 1'b1;
    begin
      exp_t e;
      e.e0 = model(13, 13, 1'b0);
      e.e1 = model(13, 13, 1'b1);
      e.req = "R2 latency";
      sb.push_back(e);
    end
    @(negedge clk);
    pixValid = 1'b0;
    checks++;
    if (outValid !== 1'b0) begin
      failures++;
      $display("FAIL R2 one edge: actual %b expected 0", outValid);
    end
    @(negedge clk);
    checks++;
    if (outValid !== 1'b1) begin
      failures++;
      $display("FAIL R2 two edges: actual %b expected 1", outValid);
    end

    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R2 missing results: actual %0d pending expected 0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule